// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Timer

This block sequences one programmed-I/O register access on a parallel ATA cable. A host request names the direction, the target device, a chip-select line, a register address and, for writes, a 16-bit data word. The block first drives the address and the chosen chip-select. It then pulls the read or write strobe low, releases it, and keeps the write data on the bus for a hold time. A recovery interval with the bus idle follows. It ends with a one-cycle completion pulse. For reads, the data bus is captured on the clock edge that releases the strobe.

Each of the four phases takes its length from an 8-bit field of a 32-bit timing word. By default that word is the shared command timing word. A per-device enable switches a device to its own fast timing word. Each timing set has its own enable that decides whether a low IORDY may stretch the strobe. The timing word and the IORDY choice are frozen when a request is accepted. A core enable gates acceptance, and a separate control input drives the active-low bus reset line.

Top module: `pata_pio_timer`

## Requirements
- R1: While rst_n is low: busy and done are 0, both strobes are 1, every chip-select is 1, bus_dd_oe is 0 and bus_rst_n is 0.
- R2: A request is accepted on a clock edge where req_valid and core_en are 1 and busy is 0. busy is 1 from the next cycle on. Requests while busy or with core_en at 0 change nothing on the bus.
- R3: Timing word layout: bits 7:0 setup, 15:8 strobe width, 23:16 hold, 31:24 recovery. Each phase lasts its field value plus one cycle, in the order setup, strobe, hold, recovery, followed by one done cycle.
- R4: A read pulls only bus_dior_n low and a write only bus_diow_n low, and only during the strobe phase. The two are never low together.
- R5: During the strobe and hold phases of a write, bus_dd_oe is 1 and bus_dd_out equals the accepted write data. At every other time bus_dd_oe is 0.
- R6: For a read, rsp_rdata takes bus_dd_in on the edge that ends the strobe. It holds that value through the done cycle and afterwards.
- R7: If fast_en[d] is 1 for the requested device d, the access uses fast_timing[32*d+31:32*d]. Otherwise it uses cmd_timing.
- R8: For the timing set in use, the IORDY enable is rdy_en_fast[d] (fast set) or rdy_en_cmd (command set). When it is 1, every strobe cycle whose closing edge sees bus_iordy low is added to the strobe. When it is 0, bus_iordy has no effect.
- R9: Changes to the timing words, enables or request inputs after acceptance do not alter the running access.
- R10: done is high for exactly one cycle per access, with busy high. busy falls the cycle after done.
- R11: bus_rst_n equals the inverse of rst_ctl, delayed by one clock.
- R12: During setup, strobe and hold, bus_cs_n bit req_cs is 0, the other bits are 1, and bus_addr equals the accepted address. Otherwise bus_cs_n is all ones and bus_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_en | input | 1 | Allows requests to be accepted |
| rst_ctl | input | 1 | Drives the bus reset line while 1 |
| fast_en | input | NUM_DEV | Per-device select of the fast timing word |
| rdy_en_cmd | input | 1 | IORDY enable for the command timing set |
| rdy_en_fast | input | NUM_DEV | IORDY enable for each device's fast timing set |
| cmd_timing | input | 32 | Shared command timing word |
| fast_timing | input | 32*NUM_DEV | Fast timing words, device d at bits 32*d+31:32*d |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | DEV_W | Target device |
| req_cs | input | CS_SEL_W | Index of the chip-select line to drive |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address lines |
| bus_cs_n | output | CS_W | Active-low chip selects |
| bus_dior_n | output | 1 | Active-low read strobe |
| bus_diow_n | output | 1 | Active-low write strobe |
| bus_dd_out | output | DATA_W | Data driven to the bus |
| bus_dd_oe | output | 1 | Data output enable |
| bus_dd_in | input | DATA_W | Data from the bus |
| bus_iordy | input | 1 | Device ready, synchronous to clk |
| bus_rst_n | output | 1 | Active-low bus reset |

## Verification
A phase counter that is loaded with the wrong field, or that stalls when it should not, shows up as a setup, strobe, hold or recovery interval of the wrong length. The bench measures each of these intervals in cycles on the strobe and chip-select pins during the same access. A wrong captured timing set or direction shows up right away: either the wrong strobe goes low or the interval lengths match the filler word the bench places in the unused timing slots. A read-data latch on the wrong edge returns the corrupted value the bench drives during the first hold cycle. It appears in rsp_rdata at the done pulse.

// File: rtl/pata_pio_pkg.sv
// Shared definitions for the PIO cycle timer.
// Assumes a fixed 32-bit timing word made of four byte-wide phase counts.
package pata_pio_pkg;

    localparam int FIELD_W = 8;
    localparam int WORD_W  = 4 * FIELD_W;

    // Timing word: recovery in the top byte, setup in the bottom byte.
    typedef struct packed {
        logic [FIELD_W-1:0] recov;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] strobe;
        logic [FIELD_W-1:0] setup;
    } pio_timing_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOV,
        PH_DONE
    } pio_phase_t;

endpackage

// File: rtl/pata_timing_sel.sv
// Chooses the timing word and the IORDY enable for the requested device.
// Assumes fast_words packs device d at bits 32*d+31:32*d. Purely combinational.
module pata_timing_sel
    import pata_pio_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = 1
) (
    input  logic [WORD_W-1:0]         cmd_word,
    input  logic [NUM_DEV*WORD_W-1:0] fast_words,
    input  logic [NUM_DEV-1:0]        fast_en,
    input  logic                      rdy_en_cmd,
    input  logic [NUM_DEV-1:0]        rdy_en_fast,
    input  logic [DEV_W-1:0]          dev,
    output pio_timing_t               sel_word,
    output logic                      sel_rdy
);

    pio_timing_t fast_arr [NUM_DEV];

    // Split the packed fast words into one entry per device.
    generate
        for (genvar g = 0; g < NUM_DEV; g++) begin : g_unpack
            assign fast_arr[g] = fast_words[g*WORD_W +: WORD_W];
        end
    endgenerate

    // Pick the fast set for a fast-enabled device, the command set otherwise.
    always_comb begin
        sel_word = pio_timing_t'(cmd_word);
        sel_rdy  = rdy_en_cmd;
        for (int i = 0; i < NUM_DEV; i++) begin
            if ((int'(dev) == i) && fast_en[i]) begin
                sel_word = fast_arr[i];
                sel_rdy  = rdy_en_fast[i];
            end
        end
    end

endmodule

// File: rtl/pata_phase_ctrl.sv
// Phase sequencer: setup, strobe, hold, recovery, done, using one down-counter.
// Assumes bus_iordy is already synchronous to clk. The timing fields are captured at start.
module pata_phase_ctrl
    import pata_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  pio_timing_t word_in,
    input  logic        rdy_use_in,
    input  logic        iordy,
    output pio_phase_t  phase,
    output logic        strobe_end
);

    pio_phase_t         phase_q;
    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] strobe_q;
    logic [FIELD_W-1:0] hold_q;
    logic [FIELD_W-1:0] recov_q;
    logic               rdy_q;
    logic               stall;
    logic               cnt_zero;

    assign cnt_zero   = (cnt_q == '0);
    assign stall      = (phase_q == PH_STROBE) && rdy_q && !iordy;
    assign strobe_end = (phase_q == PH_STROBE) && !stall && cnt_zero;
    assign phase      = phase_q;

    // Advance through the phases, reloading the counter from the captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            strobe_q <= '0;
            hold_q   <= '0;
            recov_q  <= '0;
            rdy_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_SETUP;
                        cnt_q    <= word_in.setup;
                        strobe_q <= word_in.strobe;
                        hold_q   <= word_in.hold;
                        recov_q  <= word_in.recov;
                        rdy_q    <= rdy_use_in;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= strobe_q;
                    end else begin
                        cnt_q <= cnt_q - FIELD_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (!stall) begin
                        if (cnt_zero) begin
                            phase_q <= PH_HOLD;
                            cnt_q   <= hold_q;
                        end else begin
                            cnt_q <= cnt_q - FIELD_W'(1);
                        end
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= recov_q;
                    end else begin
                        cnt_q <= cnt_q - FIELD_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt_zero) begin
                        phase_q <= PH_DONE;
                    end else begin
                        cnt_q <= cnt_q - FIELD_W'(1);
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pata_bus_drive.sv
// Holds the accepted request and decodes the bus pins from the current phase.
// Assumes start is high only in the idle phase. Read data is latched on strobe_end.
module pata_bus_drive
    import pata_pio_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 16,
    parameter int CS_W     = 2,
    parameter int CS_SEL_W = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                req_write,
    input  logic [CS_SEL_W-1:0] req_cs,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  pio_phase_t          phase,
    input  logic                strobe_end,
    input  logic [DATA_W-1:0]   dd_in,
    output logic [ADDR_W-1:0]   addr,
    output logic [CS_W-1:0]     cs_n,
    output logic                dior_n,
    output logic                diow_n,
    output logic [DATA_W-1:0]   dd_out,
    output logic                dd_oe,
    output logic [DATA_W-1:0]   rdata
);

    logic                wr_q;
    logic [CS_SEL_W-1:0] cs_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                active;
    logic                in_strobe;

    // Capture the request fields when the access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            wr_q    <= req_write;
            cs_q    <= req_cs;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Latch read data on the edge that releases the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (strobe_end && !wr_q) begin
            rdata <= dd_in;
        end
    end

    assign active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign in_strobe = (phase == PH_STROBE);

    assign addr   = active ? addr_q : '0;
    assign dior_n = !(in_strobe && !wr_q);
    assign diow_n = !(in_strobe && wr_q);
    assign dd_oe  = wr_q && (in_strobe || (phase == PH_HOLD));
    assign dd_out = dd_oe ? wdata_q : '0;

    // One active-low select per line; only the captured index goes low.
    generate
        for (genvar g = 0; g < CS_W; g++) begin : g_cs
            assign cs_n[g] = !(active && (cs_q == CS_SEL_W'(g)));
        end
    endgenerate

endmodule

// File: rtl/pata_pio_timer.sv
// Top of the PIO cycle timer: request acceptance, timing selection, phase
// sequencing and bus pin decode. Assumes bus_iordy is synchronous to clk.
module pata_pio_timer
    import pata_pio_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 16,
    parameter int CS_W    = 2,
    parameter int NUM_DEV = 2,
    localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int CS_SEL_W = (CS_W > 1) ? $clog2(CS_W) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      core_en,
    input  logic                      rst_ctl,
    input  logic [NUM_DEV-1:0]        fast_en,
    input  logic                      rdy_en_cmd,
    input  logic [NUM_DEV-1:0]        rdy_en_fast,
    input  logic [WORD_W-1:0]         cmd_timing,
    input  logic [NUM_DEV*WORD_W-1:0] fast_timing,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [DEV_W-1:0]          req_dev,
    input  logic [CS_SEL_W-1:0]       req_cs,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      busy,
    output logic                      done,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [CS_W-1:0]           bus_cs_n,
    output logic                      bus_dior_n,
    output logic                      bus_diow_n,
    output logic [DATA_W-1:0]         bus_dd_out,
    output logic                      bus_dd_oe,
    input  logic [DATA_W-1:0]         bus_dd_in,
    input  logic                      bus_iordy,
    output logic                      bus_rst_n
);

    pio_phase_t  phase;
    pio_timing_t sel_word;
    logic        sel_rdy;
    logic        start;
    logic        strobe_end;

    assign busy  = (phase != PH_IDLE);
    assign done  = (phase == PH_DONE);
    assign start = req_valid && core_en && !busy;

    // Register the bus reset line; held asserted during chip reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rst_n <= 1'b0;
        end else begin
            bus_rst_n <= !rst_ctl;
        end
    end

    pata_timing_sel #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) u_sel (
        .cmd_word    (cmd_timing),
        .fast_words  (fast_timing),
        .fast_en     (fast_en),
        .rdy_en_cmd  (rdy_en_cmd),
        .rdy_en_fast (rdy_en_fast),
        .dev         (req_dev),
        .sel_word    (sel_word),
        .sel_rdy     (sel_rdy)
    );

    pata_phase_ctrl u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_in    (sel_word),
        .rdy_use_in (sel_rdy),
        .iordy      (bus_iordy),
        .phase      (phase),
        .strobe_end (strobe_end)
    );

    pata_bus_drive #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CS_W     (CS_W),
        .CS_SEL_W (CS_SEL_W)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_write  (req_write),
        .req_cs     (req_cs),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .phase      (phase),
        .strobe_end (strobe_end),
        .dd_in      (bus_dd_in),
        .addr       (bus_addr),
        .cs_n       (bus_cs_n),
        .dior_n     (bus_dior_n),
        .diow_n     (bus_diow_n),
        .dd_out     (bus_dd_out),
        .dd_oe      (bus_dd_oe),
        .rdata      (rsp_rdata)
    );

endmodule

// File: rtl/pata_pio_timer_chk.sv
// Property checker for the PIO cycle timer, attached to the top by bind.
// Observes only ports of the top module.
module pata_pio_timer_chk #(
    parameter int CS_W   = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_en,
    input logic              rst_ctl,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [CS_W-1:0]   bus_cs_n,
    input logic              bus_dior_n,
    input logic              bus_diow_n,
    input logic              bus_dd_oe,
    input logic              bus_rst_n
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_dior_n && !bus_diow_n)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (bus_dior_n && bus_diow_n && !bus_dd_oe)); // R4
    AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n) (!bus_dior_n || !bus_diow_n) |-> ($countones(~bus_cs_n) == 1)); // R12
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~bus_cs_n)); // R12
    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n) bus_dd_oe |-> bus_dior_n); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R10
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done)); // R10
    AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req_valid && core_en)); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $past(bus_dior_n) |-> $stable(rsp_rdata)); // R6
    AST_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> (bus_rst_n == !$past(rst_ctl))); // R11

endmodule

bind pata_pio_timer pata_pio_timer_chk #(
    .CS_W   (CS_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_en    (core_en),
    .rst_ctl    (rst_ctl),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .rsp_rdata  (rsp_rdata),
    .bus_cs_n   (bus_cs_n),
    .bus_dior_n (bus_dior_n),
    .bus_diow_n (bus_diow_n),
    .bus_dd_oe  (bus_dd_oe),
    .bus_rst_n  (bus_rst_n)
);

// File: tb/pata_pio_timer_tb.sv
// Self-checking bench: a vector table of accesses measured phase by phase,
// then directed tests for reset, bus reset, gating and mid-access changes.
module pata_pio_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_en = 1'b0;
    logic        rst_ctl = 1'b0;
    logic [1:0]  fast_en = '0;
    logic        rdy_en_cmd = 1'b0;
    logic [1:0]  rdy_en_fast = '0;
    logic [31:0] cmd_timing = '0;
    logic [63:0] fast_timing = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [0:0]  req_dev = '0;
    logic [0:0]  req_cs = '0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rsp_rdata;
    logic [2:0]  bus_addr;
    logic [1:0]  bus_cs_n;
    logic        bus_dior_n, bus_diow_n;
    logic [15:0] bus_dd_out;
    logic        bus_dd_oe;
    logic [15:0] bus_dd_in = '0;
    logic        bus_iordy = 1'b1;
    logic        bus_rst_n;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pata_pio_timer u_dut (
        .clk (clk), .rst_n (rst_n), .core_en (core_en), .rst_ctl (rst_ctl),
        .fast_en (fast_en), .rdy_en_cmd (rdy_en_cmd), .rdy_en_fast (rdy_en_fast),
        .cmd_timing (cmd_timing), .fast_timing (fast_timing),
        .req_valid (req_valid), .req_write (req_write), .req_dev (req_dev),
        .req_cs (req_cs), .req_addr (req_addr), .req_wdata (req_wdata),
        .busy (busy), .done (done), .rsp_rdata (rsp_rdata),
        .bus_addr (bus_addr), .bus_cs_n (bus_cs_n),
        .bus_dior_n (bus_dior_n), .bus_diow_n (bus_diow_n),
        .bus_dd_out (bus_dd_out), .bus_dd_oe (bus_dd_oe), .bus_dd_in (bus_dd_in),
        .bus_iordy (bus_iordy), .bus_rst_n (bus_rst_n)
    );

    typedef struct packed {
        logic       wr;
        logic       dev;
        logic [1:0] fen;
        logic       rcmd;
        logic [1:0] rfast;
        logic [3:0] k;
        logic [7:0] t1;
        logic [7:0] t2;
        logic [7:0] t4;
        logic [7:0] teoc;
        logic [15:0] data;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 4'd0, 8'd0, 8'd0, 8'd0, 8'd0, 16'h1234},
        '{1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 4'd0, 8'd2, 8'd3, 8'd1, 8'd0, 16'hBEEF},
        '{1'b0, 1'b0, 2'b01, 1'b0, 2'b00, 4'd0, 8'd1, 8'd4, 8'd2, 8'd3, 16'h0F0F},
        '{1'b1, 1'b1, 2'b10, 1'b0, 2'b00, 4'd0, 8'd0, 8'd1, 8'd5, 8'd2, 16'hC3A5},
        '{1'b0, 1'b1, 2'b01, 1'b0, 2'b00, 4'd0, 8'd3, 8'd2, 8'd0, 8'd1, 16'h7E81},
        '{1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 4'd3, 8'd1, 8'd2, 8'd1, 8'd1, 16'h5555},
        '{1'b1, 1'b0, 2'b01, 1'b0, 2'b01, 4'd2, 8'd0, 8'd0, 8'd0, 8'd0, 16'hAAAA},
        '{1'b0, 1'b1, 2'b10, 1'b1, 2'b00, 4'd4, 8'd1, 8'd1, 8'd1, 8'd1, 16'h9001},
        '{1'b1, 1'b0, 2'b00, 1'b0, 2'b11, 4'd2, 8'd2, 8'd0, 8'd2, 8'd0, 16'h3C3C}
    };

    localparam logic [31:0] FILLER = 32'h0505_0505;

    // Record one check; a failure prints the requirement and both values.
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one request and measure every phase on the bus pins.
    task automatic run_acc(input logic wr, input logic dev, input logic cs,
                           input logic [2:0] addr, input logic [15:0] wd,
                           input logic [15:0] rd, input int stall_k, input bit perturb,
                           output int ns, output int nst, output int nh, output int nr,
                           output int b_strobe, output int b_bus, output int b_data,
                           output logic [15:0] got, output bit saw_done);
        int stage;
        logic strobe_on, cs_act, exp_oe;
        logic [1:0] exp_cs;
        ns = 0; nst = 0; nh = 0; nr = 0;
        b_strobe = 0; b_bus = 0; b_data = 0; got = '0; saw_done = 0;
        stage = 0;
        exp_cs = cs ? 2'b01 : 2'b10;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_dev = dev; req_cs = cs;
        req_addr = addr; req_wdata = wd; bus_dd_in = rd; bus_iordy = 1'b1;
        @(negedge clk);
        if (perturb) begin
            req_addr = ~addr; req_wdata = ~wd; req_write = ~wr;
            cmd_timing = 32'h2020_2020; fast_timing = '1;
        end else begin
            req_valid = 1'b0;
        end
        for (int c = 0; c < 3000; c++) begin
            if (done) begin
                got = rsp_rdata;
                saw_done = 1;
                break;
            end
            if (!busy) b_bus++;
            strobe_on = !bus_dior_n || !bus_diow_n;
            cs_act = (bus_cs_n != 2'b11);
            if (strobe_on) begin
                stage = 1;
                nst++;
                if (wr ? (!bus_dior_n || bus_diow_n) : (!bus_diow_n || bus_dior_n)) b_strobe++;
                bus_iordy = !((nst - 1) < stall_k);
            end else begin
                bus_iordy = 1'b1;
                if (cs_act) begin
                    if (stage == 0) ns++;
                    else begin
                        if (stage == 1) begin
                            stage = 2;
                            bus_dd_in = ~rd;
                        end
                        nh++;
                    end
                end else begin
                    nr++;
                end
            end
            if (strobe_on || cs_act) begin
                if (bus_cs_n != exp_cs || bus_addr != addr) b_bus++;
            end else if (bus_cs_n != 2'b11 || bus_addr != 3'd0) b_bus++;
            exp_oe = wr && (strobe_on || (stage == 2 && cs_act));
            if (bus_dd_oe != exp_oe || (exp_oe && bus_dd_out != wd)) b_data++;
            if (perturb && c == 3) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        bus_iordy = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ns, nst, nh, nr, bs, bb, bd, viol;
        logic [15:0] got;
        bit sd;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        chk(bus_dior_n && bus_diow_n, "R1", "strobes in reset", {bus_dior_n, bus_diow_n}, 3);
        chk(bus_cs_n == 2'b11 && !bus_dd_oe, "R1", "cs/oe in reset", {bus_cs_n, bus_dd_oe}, 6);
        chk(bus_rst_n == 1'b0, "R1", "bus reset in reset", bus_rst_n, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: bus reset follows the control input one clock later
        chk(bus_rst_n == 1'b1, "R11", "bus reset released", bus_rst_n, 1);
        rst_ctl = 1'b1;
        @(negedge clk);
        chk(bus_rst_n == 1'b0, "R11", "bus reset asserted", bus_rst_n, 0);
        rst_ctl = 1'b0;
        @(negedge clk);
        chk(bus_rst_n == 1'b1, "R11", "bus reset cleared", bus_rst_n, 1);

        // R2: no acceptance while the core is disabled
        cmd_timing = 32'h0000_0000;
        req_valid = 1'b1; req_addr = 3'd5;
        viol = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (busy || bus_cs_n != 2'b11 || !bus_dior_n) viol++;
        end
        req_valid = 1'b0;
        chk(viol == 0, "R2", "activity with core disabled", viol, 0);
        core_en = 1'b1;

        // Table of accesses: phase lengths, strobes, selects, data, timing choice
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic [31:0] w;
            bit fast, ruse;
            int exp_st;
            logic [15:0] rdv;
            v = VECS[i];
            w = {v.teoc, v.t4, v.t2, v.t1};
            fast = v.fen[v.dev];
            ruse = fast ? v.rfast[v.dev] : v.rcmd;
            cmd_timing = fast ? FILLER : w;
            fast_timing = {FILLER, FILLER};
            if (fast) fast_timing[v.dev*32 +: 32] = w;
            fast_en = v.fen; rdy_en_cmd = v.rcmd; rdy_en_fast = v.rfast;
            exp_st = int'(v.t2) + 1 + (ruse ? int'(v.k) : 0);
            rdv = v.data ^ 16'hA5A5;
            run_acc(v.wr, v.dev, i[0], i[2:0], v.data, rdv, int'(v.k), 1'b0,
                    ns, nst, nh, nr, bs, bb, bd, got, sd);
            chk(sd, "R10", $sformatf("vec %0d done seen", i), sd, 1);
            chk(ns == int'(v.t1) + 1, "R3 R7", $sformatf("vec %0d setup cycles", i), ns, int'(v.t1) + 1);
            chk(nst == exp_st, "R3 R8", $sformatf("vec %0d strobe cycles", i), nst, exp_st);
            chk(nh == int'(v.t4) + 1, "R3", $sformatf("vec %0d hold cycles", i), nh, int'(v.t4) + 1);
            chk(nr == int'(v.teoc) + 1, "R3", $sformatf("vec %0d recovery cycles", i), nr, int'(v.teoc) + 1);
            chk(bs == 0, "R4", $sformatf("vec %0d strobe polarity errors", i), bs, 0);
            chk(bb == 0, "R12", $sformatf("vec %0d select/address errors", i), bb, 0);
            chk(bd == 0, "R5", $sformatf("vec %0d write data errors", i), bd, 0);
            if (!v.wr) chk(got == rdv, "R6", $sformatf("vec %0d read data", i), got, rdv);
            @(negedge clk);
            chk(!busy && !done, "R10", $sformatf("vec %0d idle after done", i), {busy, done}, 0);
        end

        // R9 and R2: inputs changed and request held during an access
        fast_en = 2'b00; rdy_en_cmd = 1'b0; rdy_en_fast = 2'b00;
        cmd_timing = {8'd1, 8'd1, 8'd2, 8'd1};
        fast_timing = {FILLER, FILLER};
        run_acc(1'b1, 1'b0, 1'b1, 3'd6, 16'h6A6A, 16'h0000, 0, 1'b1,
                ns, nst, nh, nr, bs, bb, bd, got, sd);
        chk(ns == 2 && nst == 3, "R9", "setup+strobe after mid-access change", ns * 10 + nst, 23);
        chk(nh == 2 && nr == 2, "R9", "hold+recovery after mid-access change", nh * 10 + nr, 22);
        chk(bb == 0, "R2", "bus kept first request's select/address", bb, 0);
        chk(bd == 0 && bs == 0, "R2", "first request's direction and data kept", bd + bs, 0);
        @(negedge clk);
        chk(!busy, "R10", "idle after held request dropped", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule